// File: doc/BRIEF.md
# Double-Length Accumulator Execute Unit

This block is the arithmetic core of a two-address word machine built around a double-length accumulator. It holds an accumulator of twice the word width, seen as a high half and a low half, and a single-word mask register. Each operation takes one memory word that has already been fetched. It widens that word in one of three ways: by copying its top bit, by padding with zeros, or by ANDing it with the mask register. It then loads, adds or subtracts the result in ones' complement. It may then rotate the whole accumulator, or the mask register, left by a count. It returns one word to be written back to memory.

Operations enter through a valid/ready handshake. The block takes an operation on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` stays low from that edge until the result is produced, so a caller can hold `op_valid` high and wait. The result side has no back-pressure. `res_valid` is a one-cycle pulse, and `res_data` keeps its value until the next result. The surrounding sequencer handles memory traffic, instruction fetch and address decoding.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset the accumulator and mask register are zero, `res_valid` is low, `res_data` is zero and `op_ready` is high.
- R2: Code 0 adds and code 1 subtracts the sign-extended word (high half filled with the word's top bit) to or from the accumulator. The arithmetic is ones' complement across the full double width: a carry out of the top bit is added back at bit 0, and subtraction adds the bitwise complement. The result is the low half.
- R3: Code 2 loads the zero-extended word into the accumulator, and code 3 loads the complement of that full double-width value. Either one then rotates the whole accumulator left by `op_count` places. The result is the low half.
- R4: Code 4 adds and code 5 subtracts the zero-extended word in ones' complement, then rotates the accumulator left by `op_count`. The result is the low half.
- R5: Code 6 loads, and code 7 adds, a value that is zero in the high half and holds (mask register AND word) in the low half. The result is the low half.
- R6: Code 8 rotates the accumulator left by `op_count`. With `op_take_right` at 0 the result is the high half; with it at 1 the result is the low half.
- R7: Code 9 loads the sign-extended word, rotates left by `op_count` and returns the low half. With `op_keep_a` high the load is skipped and the existing accumulator is rotated.
- R8: Code 10 loads the word into the mask register and rotates the mask register left by `op_count` within one word. The result is the new mask register value. The accumulator is left unchanged. No other code alters the mask register.
- R9: For codes 2, 3, 4, 5, 8, 9 and 10, `res_valid` pulses for one cycle `op_count`+1 cycles after the accepting edge. All other codes ignore `op_count` and pulse one cycle after acceptance. `op_ready` rises together with `res_valid`.
- R10: While `op_ready` is low, `op_valid` and the other operation inputs have no effect. `res_data` changes only on a cycle where `res_valid` is high.
- R11: Codes 11 to 15 leave the accumulator and mask register unchanged, take one cycle and return the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | Block is idle and takes the offered operation |
| op_code | input | 4 | Operation code |
| op_word | input | WORD_W | Fetched memory operand |
| op_count | input | CNT_W | Left rotate count |
| op_take_right | input | 1 | For code 8, selects the low half as result |
| op_keep_a | input | 1 | For code 9, rotates the existing accumulator without loading |
| res_valid | output | 1 | One-cycle pulse, result is ready |
| res_data | output | WORD_W | Word to be stored, held until the next result |

## Verification
The bench runs a 4-bit-word configuration, which makes every word and every rotate count, including counts past the accumulator width, cheap to try. Add and subtract run over all words against accumulators of both signs, so sign extension and the end-around carry, including results of minus zero, are separated from plain binary arithmetic. Split entry and rotation run through every count, which tests the zero-padded and complemented loads and the wrap of bits from the top half into the low half. After each operation the high half is read back through the half-select rotate. Mask tests pair every mask with every word. The busy test offers a conflicting operation during a long rotate to show that the block ignores it.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD_T     = 4'd0,
    OP_SUB_T     = 4'd1,
    OP_SPLIT_POS = 4'd2,
    OP_SPLIT_NEG = 4'd3,
    OP_SPLIT_ADD = 4'd4,
    OP_SPLIT_SUB = 4'd5,
    OP_Q_XFER    = 4'd6,
    OP_Q_ADD     = 4'd7,
    OP_LEFT_T    = 4'd8,
    OP_SHIFT_A   = 4'd9,
    OP_SHIFT_Q   = 4'd10
  } acc_op_e;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_LOAD,
    ACC_ADD
  } acc_mode_e;

  // Codes whose count field drives the rotate phase (R9).
  function automatic logic op_uses_count(input logic [3:0] code);
    logic r;
    case (code)
      OP_SPLIT_POS, OP_SPLIT_NEG, OP_SPLIT_ADD, OP_SPLIT_SUB,
      OP_LEFT_T, OP_SHIFT_A, OP_SHIFT_Q: r = 1'b1;
      default:                           r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acc_oc_adder.sv
// Ones' complement adder with end-around carry.
module acc_oc_adder #(
  parameter int N = 72
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);
  logic [N:0] raw;

  assign raw = {1'b0, x} + {1'b0, y};
  assign s   = raw[N-1:0] + {{(N-1){1'b0}}, raw[N]};
endmodule

// File: rtl/acc_operand_mux.sv
// Widens the fetched word and chooses how it meets the accumulator.
module acc_operand_mux
  import acc_exec_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic [3:0]          op_code,
  input  logic [WORD_W-1:0]   word,
  input  logic [WORD_W-1:0]   q,
  input  logic                keep_a,
  output logic [2*WORD_W-1:0] operand,
  output acc_mode_e           mode
);
  localparam int ACC_W = 2 * WORD_W;

  logic [ACC_W-1:0] sext, zext, qmask;

  assign sext  = {{WORD_W{word[WORD_W-1]}}, word};
  assign zext  = {{WORD_W{1'b0}}, word};
  assign qmask = {{WORD_W{1'b0}}, q & word};

  always_comb begin
    operand = zext;
    mode    = ACC_HOLD;
    case (op_code)
      OP_ADD_T:     begin operand = sext;   mode = ACC_ADD;  end
      OP_SUB_T:     begin operand = ~sext;  mode = ACC_ADD;  end
      OP_SPLIT_POS: begin operand = zext;   mode = ACC_LOAD; end
      OP_SPLIT_NEG: begin operand = ~zext;  mode = ACC_LOAD; end
      OP_SPLIT_ADD: begin operand = zext;   mode = ACC_ADD;  end
      OP_SPLIT_SUB: begin operand = ~zext;  mode = ACC_ADD;  end
      OP_Q_XFER:    begin operand = qmask;  mode = ACC_LOAD; end
      OP_Q_ADD:     begin operand = qmask;  mode = ACC_ADD;  end
      OP_SHIFT_A: begin
        operand = sext;
        mode    = keep_a ? ACC_HOLD : ACC_LOAD;
      end
      default: begin
        operand = zext;
        mode    = ACC_HOLD;
      end
    endcase
  end
endmodule

// File: rtl/acc_step_ctrl.sv
// Idle / rotate sequencer with a down-counter.
module acc_step_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             use_count,
  input  logic [CNT_W-1:0] count,
  output logic             op_ready,
  output logic             accept,
  output logic             rot_en,
  output logic             finish
);
  typedef enum logic {ST_IDLE, ST_ROT} st_e;

  st_e              st;
  logic [CNT_W-1:0] cnt;

  assign op_ready = (st == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign rot_en   = (st == ST_ROT) && (cnt != '0);
  assign finish   = (st == ST_ROT) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      if (accept) begin
        st  <= ST_ROT;
        cnt <= use_count ? count : '0;
      end
      if (rot_en) cnt <= cnt - 1'b1;
      if (finish) st <= ST_IDLE;
    end
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [3:0]        op_code,
  input  logic [WORD_W-1:0] op_word,
  input  logic [CNT_W-1:0]  op_count,
  input  logic              op_take_right,
  input  logic              op_keep_a,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data
);
  localparam int ACC_W = 2 * WORD_W;

  logic [ACC_W-1:0]  a_reg;
  logic [WORD_W-1:0] q_reg;
  logic [3:0]        cur_code;
  logic              cur_right;

  logic              accept, rot_en, finish, use_count;
  logic [ACC_W-1:0]  operand, sum, a_load;
  acc_mode_e         mode;
  logic [WORD_W-1:0] out_sel;

  assign use_count = op_uses_count(op_code);

  acc_step_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .use_count (use_count),
    .count     (op_count),
    .op_ready  (op_ready),
    .accept    (accept),
    .rot_en    (rot_en),
    .finish    (finish)
  );

  acc_operand_mux #(.WORD_W(WORD_W)) u_opnd (
    .op_code (op_code),
    .word    (op_word),
    .q       (q_reg),
    .keep_a  (op_keep_a),
    .operand (operand),
    .mode    (mode)
  );

  acc_oc_adder #(.N(ACC_W)) u_add (
    .x (a_reg),
    .y (operand),
    .s (sum)
  );

  always_comb begin
    case (mode)
      ACC_LOAD: a_load = operand;
      ACC_ADD:  a_load = sum;
      default:  a_load = a_reg;
    endcase
  end

  always_comb begin
    if (cur_code == OP_SHIFT_Q)
      out_sel = q_reg;
    else if (cur_code == OP_LEFT_T && !cur_right)
      out_sel = a_reg[ACC_W-1:WORD_W];
    else
      out_sel = a_reg[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_reg     <= '0;
      q_reg     <= '0;
      cur_code  <= '0;
      cur_right <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (accept) begin
        a_reg     <= a_load;
        cur_code  <= op_code;
        cur_right <= op_take_right;
        if (op_code == OP_SHIFT_Q) q_reg <= op_word;
      end
      if (rot_en) begin
        if (cur_code == OP_SHIFT_Q)
          q_reg <= {q_reg[WORD_W-2:0], q_reg[WORD_W-1]};
        else
          a_reg <= {a_reg[ACC_W-2:0], a_reg[ACC_W-1]};
      end
      if (finish) begin
        res_valid <= 1'b1;
        res_data  <= out_sel;
      end
    end
  end
endmodule

// File: rtl/acc_exec_unit_chk.sv
module acc_exec_unit_chk
  import acc_exec_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [3:0]        op_code,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_data,
  input logic [WORD_W-1:0] q_reg
);
  // R9: result strobe lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: block is ready again when the result appears
  a_r9_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> op_ready);

  // R9: ready only comes back through a result
  a_r9_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_ready) |-> res_valid);

  // R10: an accepted operation blocks further offers on the next cycle
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);

  // R10: result data moves only with the strobe
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

  // R8: while idle, only a mask-load code may alter the mask register
  a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !(op_valid && op_code == OP_SHIFT_Q)) |=> $stable(q_reg));
endmodule

bind acc_exec_unit acc_exec_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .op_code   (op_code),
  .res_valid (res_valid),
  .res_data  (res_data),
  .q_reg     (q_reg)
);

// File: tb/tb_acc_exec_unit.sv
`timescale 1ns/1ps
module tb_acc_exec_unit;
  import acc_exec_pkg::*;

  localparam int W  = 4;
  localparam int AW = 2 * W;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [3:0]    op_code = '0;
  logic [W-1:0]  op_word = '0;
  logic [CW-1:0] op_count = '0;
  logic          op_take_right = 1'b0;
  logic          op_keep_a = 1'b0;
  logic          res_valid;
  logic [W-1:0]  res_data;

  int n_run = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  logic [AW-1:0] ma = '0;
  logic [W-1:0]  mq = '0;

  always #2 clk = ~clk;

  acc_exec_unit #(.WORD_W(W), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_word(op_word), .op_count(op_count),
    .op_take_right(op_take_right), .op_keep_a(op_keep_a),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [AW-1:0] oc_add(input logic [AW-1:0] x, input logic [AW-1:0] y);
    int s;
    s = int'(x) + int'(y);
    if (s > (1 << AW) - 1) s = s - ((1 << AW) - 1);
    return AW'(s);
  endfunction

  function automatic logic [AW-1:0] rot_a(input logic [AW-1:0] x, input int k);
    logic [AW-1:0] r = x;
    for (int i = 0; i < k; i++) r = {r[AW-2:0], r[AW-1]};
    return r;
  endfunction

  function automatic logic [W-1:0] rot_q(input logic [W-1:0] x, input int k);
    logic [W-1:0] r = x;
    for (int i = 0; i < k; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  function automatic logic [AW-1:0] sx(input logic [W-1:0] w);
    return {{W{w[W-1]}}, w};
  endfunction

  function automatic logic [AW-1:0] zx(input logic [W-1:0] w);
    return {{W{1'b0}}, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Applies one operation, predicts result and latency, checks both.
  task automatic run_op(input logic [3:0] code, input logic [W-1:0] w, input int k,
                        input logic right, input logic keep, input string tag);
    logic [W-1:0] exp;
    int exp_cyc;
    int cyc;
    exp_cyc = 1;
    case (code)
      OP_ADD_T:     ma = oc_add(ma, sx(w));
      OP_SUB_T:     ma = oc_add(ma, ~sx(w));
      OP_SPLIT_POS: ma = rot_a(zx(w), k);
      OP_SPLIT_NEG: ma = rot_a(~zx(w), k);
      OP_SPLIT_ADD: ma = rot_a(oc_add(ma, zx(w)), k);
      OP_SPLIT_SUB: ma = rot_a(oc_add(ma, ~zx(w)), k);
      OP_Q_XFER:    ma = zx(mq & w);
      OP_Q_ADD:     ma = oc_add(ma, zx(mq & w));
      OP_LEFT_T:    ma = rot_a(ma, k);
      OP_SHIFT_A:   ma = rot_a(keep ? ma : sx(w), k);
      OP_SHIFT_Q:   mq = rot_q(w, k);
      default: ;
    endcase
    if (code == OP_SHIFT_Q) exp = mq;
    else if (code == OP_LEFT_T && !right) exp = ma[AW-1:W];
    else exp = ma[W-1:0];
    if (code >= 4'd2 && code <= 4'd10 && code != 4'd6 && code != 4'd7) exp_cyc = k + 1;

    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_word = w; op_count = CW'(k);
    op_take_right = right; op_keep_a = keep;
    @(negedge clk);
    op_valid = 1'b0;
    cyc = 0;
    while (!res_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(tag, 32'(res_data), 32'(exp));
    check("R9 latency", 32'(cyc), 32'(exp_cyc));
  endtask

  task automatic set_a(input logic [AW-1:0] v);
    run_op(OP_SPLIT_POS, v[AW-1:W], W, 1'b0, 1'b0, "R3");
    run_op(OP_SPLIT_ADD, v[W-1:0], 0, 1'b0, 1'b0, "R4");
  endtask

  task automatic read_high(input string tag);
    run_op(OP_LEFT_T, '0, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 ready", 32'(op_ready), 32'd1);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 res_data", 32'(res_data), 32'd0);
    run_op(OP_LEFT_T, '0, 0, 1'b1, 1'b0, "R1 low half");
    read_high("R1 high half");
    run_op(OP_Q_XFER, '1, 0, 1'b0, 1'b0, "R1 mask");

    // R2: sign-extended add/subtract over all words and spread accumulators
    for (int av = 0; av < 16; av++) begin
      for (int w = 0; w < 16; w++) begin
        set_a(AW'(av * 17 ^ 8'h5A));
        run_op(OP_ADD_T, W'(w), 0, 1'b0, 1'b0, "R2 add");
        read_high("R2 add high");
        set_a(AW'(av * 17));
        run_op(OP_SUB_T, W'(w), 0, 1'b0, 1'b0, "R2 sub");
        read_high("R2 sub high");
      end
    end

    // R3: split entry, every word and count
    for (int w = 0; w < 16; w++) begin
      for (int k = 0; k < 16; k++) begin
        run_op(OP_SPLIT_POS, W'(w), k, 1'b0, 1'b0, "R3 pos");
        read_high("R3 pos high");
        run_op(OP_SPLIT_NEG, W'(w), k, 1'b0, 1'b0, "R3 neg");
        read_high("R3 neg high");
      end
    end

    // R4: split add/subtract
    for (int av = 0; av < 8; av++) begin
      for (int w = 0; w < 16; w++) begin
        set_a(AW'(av * 37));
        run_op(OP_SPLIT_ADD, W'(w), (w + av) % 11, 1'b0, 1'b0, "R4 add");
        read_high("R4 add high");
        set_a(AW'(av * 29 + 3));
        run_op(OP_SPLIT_SUB, W'(w), (w * 3 + av) % 13, 1'b0, 1'b0, "R4 sub");
        read_high("R4 sub high");
      end
    end

    // R5, R8: every mask against every word
    for (int qv = 0; qv < 16; qv++) begin
      run_op(OP_SHIFT_Q, W'(qv), 0, 1'b0, 1'b0, "R8 load");
      for (int w = 0; w < 16; w++) begin
        run_op(OP_Q_XFER, W'(w), 0, 1'b0, 1'b0, "R5 xfer");
        read_high("R5 xfer high");
        set_a(AW'(qv * 16 + w));
        run_op(OP_Q_ADD, W'(w), 0, 1'b0, 1'b0, "R5 add");
        read_high("R5 add high");
      end
    end

    // R6: rotate with both half selections
    set_a(8'hB4);
    for (int k = 0; k < 16; k++) begin
      run_op(OP_LEFT_T, '0, k, 1'b0, 1'b0, "R6 high");
      run_op(OP_LEFT_T, '0, k, 1'b1, 1'b0, "R6 low");
    end

    // R7: load-and-rotate, and rotate in place
    for (int w = 0; w < 16; w++) begin
      for (int k = 0; k < 10; k++) begin
        run_op(OP_SHIFT_A, W'(w), k, 1'b0, 1'b0, "R7 load");
        read_high("R7 load high");
        run_op(OP_SHIFT_A, W'(~w), k, 1'b0, 1'b1, "R7 keep");
        read_high("R7 keep high");
      end
    end

    // R8: mask rotate leaves accumulator alone
    set_a(8'h6C);
    for (int w = 0; w < 16; w++) begin
      for (int k = 0; k < 9; k++) begin
        run_op(OP_SHIFT_Q, W'(w), k, 1'b0, 1'b0, "R8 rotate");
      end
      read_high("R8 acc high");
      run_op(OP_LEFT_T, '0, 0, 1'b1, 1'b0, "R8 acc low");
      run_op(OP_Q_XFER, '1, 0, 1'b0, 1'b0, "R8 mask readback");
    end

    // R10: offer during a long rotate is ignored
    run_op(OP_SHIFT_Q, 4'h9, 0, 1'b0, 1'b0, "R10 setup");
    @(negedge clk);
    op_valid = 1'b1; op_code = OP_SPLIT_POS; op_word = 4'h5; op_count = CW'(6);
    op_take_right = 1'b0; op_keep_a = 1'b0;
    ma = rot_a(zx(4'h5), 6);
    @(negedge clk);
    op_code = OP_SHIFT_Q; op_word = 4'hA; op_count = '0;
    for (int i = 0; i < 3; i++) begin
      check("R10 busy", 32'(op_ready), 32'd0);
      @(negedge clk);
    end
    op_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check("R10 result", 32'(res_data), 32'(ma[W-1:0]));
    read_high("R10 high");
    run_op(OP_Q_XFER, '1, 0, 1'b0, 1'b0, "R10 mask kept");

    // R11: undefined codes
    set_a(8'hD3);
    for (int c = 11; c < 16; c++) begin
      run_op(4'(c), 4'hF, 7, 1'b0, 1'b1, "R11 low");
      read_high("R11 high");
    end
    run_op(OP_Q_XFER, '1, 0, 1'b0, 1'b0, "R11 mask kept");

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule